// File: doc/BRIEF.md
# Bitfield Mask Generator

This unit manufactures frequently needed mask constants from two small bit-index immediates and an operand size code, so that an instruction stream does not have to carry the full constant. Its result is a single contiguous stretch of ones inside a field of zeros, or the complement: a stretch of zeros inside a field of ones. No data operand is read. The output is a function of the two indices and the size code only.

The run covers every bit position strictly above the smaller index, up to and including the larger index. The order in which the indices arrive selects the polarity. If the first index is the larger, the run is ones in zeros. If the first index is the smaller, the run is zeros in ones. The size code picks an operand of 8, 16, 32, 64 or 128 bits. Bits above the chosen size always read as zero. An index that points outside the chosen size is pulled down to the top bit of that size. The result is registered, so it appears one clock after the request, and there is no backpressure.

Top module: `maskgen_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `resValid` is 0 and `resMask` is all zeros.
- R2: `resValid` is high in exactly the cycles that directly follow a cycle with `reqValid` high. Back-to-back requests each produce a result in consecutive cycles.
- R3: When the clamped `idxFirst` is greater than the clamped `idxSecond`, `resMask` has ones at bit positions idxSecond+1 through idxFirst and zeros everywhere else.
- R4: When the clamped `idxFirst` is smaller than the clamped `idxSecond`, `resMask` has zeros at positions idxFirst+1 through idxSecond and ones at all other positions below the selected width.
- R5: When the two clamped indices are equal, `resMask` is all zeros.
- R6: The encoding of `sizeSel` is 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64 and 4 = 128. The codes 5, 6 and 7 also select 128 bits.
- R7: All bits of `resMask` at or above the selected width are 0.
- R8: An index greater than width-1 is treated as width-1 before the run is formed.
- R9: In a cycle without a request, `resMask` keeps its previous value, whatever the index and size inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe; the indices and size are sampled when it is high |
| idxFirst | input | 7 | First bit-index immediate |
| idxSecond | input | 7 | Second bit-index immediate |
| sizeSel | input | 3 | Operand size code (see R6) |
| resValid | output | 1 | Result valid, one cycle after the request |
| resMask | output | 128 | Generated mask, zero above the selected width |

## Verification
On every cycle, the assertions check the one-cycle valid timing and the clamping of the larger index. On every new result they also check that the result is a single run of the polarity the index order asks for, that it is empty when the indices meet, that the region above the width is zero, and that the result holds between requests. Only the bench's scenarios can show that a run starts and ends at exactly the right positions for each size code, including the aliased codes 5 to 7 and the indices that are clamped. The bench checks this against a model built bit by bit.

// File: rtl/maskgen_pkg.sv
package maskgen_pkg;

  // Strobes the control half hands to the datapath for one request.
  typedef struct packed {
    logic load;    // capture a new mask this cycle
    logic invert;  // zeros-in-ones polarity
    logic empty;   // indices coincide, run has no bits
  } maskStrobes_t;

endpackage

// File: rtl/maskgen_ctrl.sv
module maskgen_ctrl
  import maskgen_pkg::*;
#(
  parameter int BASE_W     = 8,
  parameter int NUM_WIDTHS = 5,
  parameter int SEL_W      = 3,
  parameter int IDX_W      = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] idxFirst,
  input  logic [IDX_W-1:0] idxSecond,
  input  logic [SEL_W-1:0] sizeSel,
  output maskStrobes_t     strobes,
  output logic [IDX_W-1:0] hiIdx,
  output logic [IDX_W-1:0] loIdx,
  output logic [IDX_W-1:0] topIdx,
  output logic             resValid
);

  localparam int MAX_SEL = NUM_WIDTHS - 1;

  logic [SEL_W-1:0] effSel;
  logic [IDX_W:0]   widthBits;
  logic [IDX_W-1:0] clampFirst;
  logic [IDX_W-1:0] clampSecond;

  // Size decode: codes past the largest size alias to it.
  always_comb begin
    effSel    = (sizeSel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sizeSel;
    widthBits = (IDX_W + 1)'(BASE_W) << effSel;
    topIdx    = IDX_W'(widthBits - 1'b1);
  end

  // Index clamping and ordering.
  always_comb begin
    clampFirst     = (idxFirst  > topIdx) ? topIdx : idxFirst;
    clampSecond    = (idxSecond > topIdx) ? topIdx : idxSecond;
    strobes.load   = reqValid;
    strobes.invert = clampFirst < clampSecond;
    strobes.empty  = clampFirst == clampSecond;
    hiIdx          = strobes.invert ? clampSecond : clampFirst;
    loIdx          = strobes.invert ? clampFirst  : clampSecond;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= reqValid;
  end

  // R2: a result follows every request after one cycle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resValid);
  // R2: no result without a request one cycle earlier
  p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !resValid);
  // R8: indices handed to the datapath never exceed the top bit of the size
  p_clamp_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (hiIdx <= topIdx) && (loIdx <= hiIdx));

endmodule

// File: rtl/maskgen_dp.sv
module maskgen_dp
  import maskgen_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  maskStrobes_t      strobes,
  input  logic [IDX_W-1:0]  hiIdx,
  input  logic [IDX_W-1:0]  loIdx,
  input  logic [IDX_W-1:0]  topIdx,
  output logic [DATA_W-1:0] resMask
);

  // Ones at positions 0..idx inclusive.
  function automatic logic [DATA_W-1:0] onesThrough(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] v;
    for (int i = 0; i < DATA_W; i++) v[i] = (i <= int'(idx));
    return v;
  endfunction

  // True when the set bits of x form one contiguous group (or none).
  function automatic logic isRun(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] y;
    y = x + (x & (~x + 1'b1));
    return (y & (y - 1'b1)) == '0;
  endfunction

  logic [DATA_W-1:0] widthMask;
  logic [DATA_W-1:0] runBits;
  logic [DATA_W-1:0] nextMask;

  always_comb begin
    widthMask = onesThrough(topIdx);
    runBits   = onesThrough(hiIdx) & ~onesThrough(loIdx);
    if (strobes.empty)       nextMask = '0;
    else if (strobes.invert) nextMask = widthMask & ~runBits;
    else                     nextMask = runBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             resMask <= '0;
    else if (strobes.load) resMask <= nextMask;
  end

  // R7: nothing above the selected width
  p_zero_ext_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (resMask & ~$past(widthMask)) == '0);
  // R3: ones-in-zeros result is one contiguous run
  p_run_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.invert) |=> isRun(resMask));
  // R4: zeros-in-ones result has one contiguous gap within the width
  p_run_zeros_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.invert) |=> isRun(~resMask & $past(widthMask)));
  // R5: coinciding indices give an empty mask
  p_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.empty) |=> resMask == '0);
  // R9: the result holds between requests
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(resMask));

endmodule

// File: rtl/maskgen_top.sv
module maskgen_top
  import maskgen_pkg::*;
#(
  parameter  int BASE_W     = 8,
  parameter  int NUM_WIDTHS = 5,
  parameter  int SEL_W      = 3,
  localparam int DATA_W     = BASE_W << (NUM_WIDTHS - 1),
  localparam int IDX_W      = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  idxFirst,
  input  logic [IDX_W-1:0]  idxSecond,
  input  logic [SEL_W-1:0]  sizeSel,
  output logic              resValid,
  output logic [DATA_W-1:0] resMask
);

  maskStrobes_t     strobes;
  logic [IDX_W-1:0] hiIdx;
  logic [IDX_W-1:0] loIdx;
  logic [IDX_W-1:0] topIdx;

  maskgen_ctrl #(
    .BASE_W(BASE_W), .NUM_WIDTHS(NUM_WIDTHS), .SEL_W(SEL_W), .IDX_W(IDX_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .idxFirst(idxFirst), .idxSecond(idxSecond), .sizeSel(sizeSel),
    .strobes(strobes), .hiIdx(hiIdx), .loIdx(loIdx), .topIdx(topIdx),
    .resValid(resValid)
  );

  maskgen_dp #(
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hiIdx(hiIdx), .loIdx(loIdx), .topIdx(topIdx),
    .resMask(resMask)
  );

endmodule

// File: tb/tb_maskgen_top.sv
`timescale 1ns/1ps
module tb_maskgen_top;

  typedef struct {
    logic [127:0] mask;
    string        tag;
  } expItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [6:0]   idxFirst = '0;
  logic [6:0]   idxSecond = '0;
  logic [2:0]   sizeSel = '0;
  logic         resValid;
  logic [127:0] resMask;

  int checks = 0;
  int errors = 0;
  bit monOn  = 0;
  bit done   = 0;
  expItem_t expQ[$];
  logic [127:0] lastMask = '0;

  always #10 clk = ~clk;  // 50 MHz

  maskgen_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .idxFirst(idxFirst), .idxSecond(idxSecond), .sizeSel(sizeSel),
    .resValid(resValid), .resMask(resMask)
  );

  // Reference built bit by bit from the requirements.
  function automatic logic [127:0] refMask(input int a, input int b, input int sel);
    logic [127:0] v;
    int w, top, ca, cb;
    w   = (sel > 4) ? 128 : (8 << sel);  // R6
    top = w - 1;
    ca  = (a > top) ? top : a;           // R8
    cb  = (b > top) ? top : b;
    v   = '0;
    if (ca > cb) begin                   // R3
      for (int i = cb + 1; i <= ca; i++) v[i] = 1'b1;
    end else if (ca < cb) begin          // R4
      for (int i = 0; i <= top; i++) v[i] = !(i > ca && i <= cb);
    end                                  // R5: equal -> zero
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input int a, input int b, input int sel, input string tag);
    expItem_t it;
    @(negedge clk); #2;
    reqValid  = 1'b1;
    idxFirst  = 7'(a);
    idxSecond = 7'(b);
    sizeSel   = 3'(sel);
    it.mask = refMask(a, b, sel);
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #2;
      reqValid  = 1'b0;
      idxFirst  = 7'($urandom);
      idxSecond = 7'($urandom);
      sizeSel   = 3'($urandom);
    end
  endtask

  // Monitor: pops the scoreboard whenever a result is due.
  always @(negedge clk) begin
    if (monOn) begin
      if (resValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected result", {127'd0, resValid}, 128'd0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(resMask === it.mask, it.tag, resMask, it.mask);
          lastMask = resMask;
        end
      end else begin
        check(expQ.size() == 0, "R2 missing result", 128'(expQ.size()), 128'd0);
        check(resMask === lastMask, "R9 hold while idle", resMask, lastMask);
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(resValid === 1'b0, "R1 valid in reset", {127'd0, resValid}, 128'd0);
    check(resMask === '0, "R1 mask in reset", resMask, 128'd0);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(resValid === 1'b0, "R1 valid after reset", {127'd0, resValid}, 128'd0);
    check(resMask === '0, "R1 mask after reset", resMask, 128'd0);
    monOn = 1;

    send(7, 2, 0,     "R3 ones 7..3 in byte");
    send(127, 0, 4,   "R3 ones 127..1 in quad");
    send(2, 7, 0,     "R4 zeros 7..3 in byte");
    send(0, 127, 4,   "R4 zeros 127..1 in quad");
    idle(2);
    send(5, 5, 2,     "R5 equal indices");
    send(100, 20, 0,  "R5 both clamped to 7");
    send(100, 3, 1,   "R8 first clamped to 15");
    send(3, 40, 2,    "R7 zeros-in-ones stays inside 32 bits");
    idle(3);
    send(120, 64, 6,  "R6 code 6 acts as 128");
    send(64, 120, 5,  "R6 code 5 acts as 128");
    send(31, 0, 2,    "R6 word full run");
    send(63, 31, 3,   "R6 double upper half");
    send(9, 12, 1,    "R4 half gap");
    idle(2);
    for (int n = 0; n < 300; n++) begin
      send(int'($urandom_range(0, 127)), int'($urandom_range(0, 127)),
           int'($urandom_range(0, 7)), "R3/R4/R7 random");
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(4);
    check(expQ.size() == 0, "R2 drained", 128'(expQ.size()), 128'd0);
    done = 1;
    summary();
    $finish;
  end

endmodule